// File: doc/BRIEF.md
# Time-shared two-digit hex display driver

This block drives a two-digit common-anode seven-segment display from two 4-bit values, one for the left digit and one for the right. It uses only one hex-to-segment decoder. The digits take turns being lit. A counter runs on every clock cycle and flips the active digit after a fixed interval. The block routes the nibble of the lit digit to the decoder, pulls that digit's enable low and holds the other enable high. At 48 MHz with a 60 Hz switching rate, the eye sees both digits lit at once.

The block also drives a 5-bit binary sum of the two inputs, which goes straight to a row of LEDs. The digit enables switch the anodes through PNP transistors, so they are active-low. The segment outputs are also active-low.

Top module: `dual_digit_mux`

## Requirements
- R1: While synchronous reset is high, and on the first cycle after it is released, the left digit is selected: `dig_en_n` = 2'b01 (bit 1 = left enable, bit 0 = right enable, 0 = lit). The interval count restarts from zero, and a reset in mid-run does the same.
- R2: Exactly one bit of `dig_en_n` is 0 in every cycle, so the two digits are never lit together.
- R3: The selected digit flips after exactly HOLD = CLK_HZ / SWITCH_HZ clock cycles. This is 800000 at the default 48 MHz and 60 Hz. After n cycles out of reset the right digit is selected when floor(n / HOLD) is odd.
- R4: `seg_n` shows the pattern of `left_nib` while the left digit is enabled, and the pattern of `right_nib` while the right digit is enabled.
- R5: `seg_n[0]` to `seg_n[6]` drive segments a to g, and 0 lights a segment. The lit segments, written as hex with bit 6 = g and bit 0 = a, are 0:3F 1:06 2:5B 3:4F 4:66 5:6D 6:7D 7:07 8:7F 9:6F A:77 b:7C C:39 d:5E E:79 F:71.
- R6: `sum` equals `left_nib + right_nib` as a 5-bit value, with the carry kept in bit 4.
- R7: The segment pattern and the enables change together on the same clock edge when the digit flips. They never refer to different digits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (48 MHz by default) |
| rst | input | 1 | Synchronous reset, active high |
| left_nib | input | 4 | Value shown on the left digit |
| right_nib | input | 4 | Value shown on the right digit |
| seg_n | output | 7 | Active-low segments a..g of the lit digit |
| dig_en_n | output | 2 | Active-low digit enables, bit 1 left, bit 0 right |
| sum | output | 5 | Binary sum of the two inputs |

## Verification
The hardest moment to reach is the clock edge where the digit flips while both input nibbles hold different values. Only there would a stale select or a mismatched enable show up. The bench builds the block with a short interval of ten cycles and changes both nibbles on every cycle through all 256 combinations, so many flips land on fresh data. A reset asserted in mid-phase then checks that the interval restarts from zero rather than resuming.

// File: rtl/dual_digit_mux.sv
module dual_digit_mux #(
  parameter int CLK_HZ    = 48_000_000,
  parameter int SWITCH_HZ = 60
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] left_nib,
  input  logic [3:0] right_nib,
  output logic [6:0] seg_n,
  output logic [1:0] dig_en_n,
  output logic [4:0] sum
);
  localparam int HOLD = CLK_HZ / SWITCH_HZ;
  localparam int CW   = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] ticks;
  logic          pick_right;
  logic [3:0]    shown;
  logic [6:0]    lit;

  always_ff @(posedge clk) begin
    if (rst) begin
      ticks      <= '0;
      pick_right <= 1'b0;
    end else if (ticks == LAST) begin
      ticks      <= '0;
      pick_right <= ~pick_right;
    end else begin
      ticks <= ticks + 1'b1;
    end
  end

  assign shown = pick_right ? right_nib : left_nib;

  always_comb begin
    case (shown)
      4'h0: lit = 7'h3F;
      4'h1: lit = 7'h06;
      4'h2: lit = 7'h5B;
      4'h3: lit = 7'h4F;
      4'h4: lit = 7'h66;
      4'h5: lit = 7'h6D;
      4'h6: lit = 7'h7D;
      4'h7: lit = 7'h07;
      4'h8: lit = 7'h7F;
      4'h9: lit = 7'h6F;
      4'hA: lit = 7'h77;
      4'hB: lit = 7'h7C;
      4'hC: lit = 7'h39;
      4'hD: lit = 7'h5E;
      4'hE: lit = 7'h79;
      default: lit = 7'h71;
    endcase
  end

  assign seg_n    = ~lit;
  assign dig_en_n = {pick_right, ~pick_right};
  assign sum      = {1'b0, left_nib} + {1'b0, right_nib};
endmodule

module dual_digit_mux_chk #(
  parameter int CLK_HZ    = 48_000_000,
  parameter int SWITCH_HZ = 60
) (
  input logic       clk,
  input logic       rst,
  input logic [3:0] left_nib,
  input logic [3:0] right_nib,
  input logic [6:0] seg_n,
  input logic [1:0] dig_en_n,
  input logic [4:0] sum
);
  localparam int HOLD = CLK_HZ / SWITCH_HZ;
  localparam int GW   = $clog2(HOLD + 2) + 1;

  logic [GW-1:0] gap;
  logic [1:0]    prev_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap     <= '0;
      prev_en <= 2'b01;
    end else begin
      prev_en <= dig_en_n;
      gap     <= (dig_en_n != prev_en) ? GW'(1) : gap + 1'b1;
    end
  end

  assert_left_after_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> dig_en_n == 2'b01);

  assert_one_lit_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(dig_en_n) == 1);

  assert_flip_interval_R3: assert property (@(posedge clk) disable iff (rst)
    (dig_en_n != prev_en) |-> gap == GW'(HOLD));

  assert_no_late_flip_R3: assert property (@(posedge clk) disable iff (rst)
    gap <= GW'(HOLD));

  assert_left_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (dig_en_n == 2'b01 && left_nib == 4'h8) |-> seg_n == 7'h00);

  assert_right_one_R4: assert property (@(posedge clk) disable iff (rst)
    (dig_en_n == 2'b10 && right_nib == 4'h1) |-> seg_n == 7'h79);

  assert_sum_carry_R6: assert property (@(posedge clk) disable iff (rst)
    (left_nib[3] && right_nib[3]) |-> sum[4]);

  assert_segs_track_en_R7: assert property (@(posedge clk) disable iff (rst)
    ($stable(dig_en_n) && $stable(left_nib) && $stable(right_nib)) |-> $stable(seg_n));
endmodule

bind dual_digit_mux dual_digit_mux_chk #(.CLK_HZ(CLK_HZ), .SWITCH_HZ(SWITCH_HZ)) u_chk (.*);

// File: tb/sim_dual_digit_mux.sv
module sim_dual_digit_mux;
  localparam int CLK_HZ = 1000, SWITCH_HZ = 100, HOLD = CLK_HZ / SWITCH_HZ;

  logic clk = 0, rst = 1;
  logic [3:0] left_nib = 0, right_nib = 0;
  logic [6:0] seg_n;
  logic [1:0] dig_en_n;
  logic [4:0] sum;
  int n = 0, checks = 0, failures = 0;
  bit done = 0;

  typedef struct { string tag; logic [1:0] en; logic [6:0] seg; logic [4:0] sm; } item_t;
  item_t q[$];
  event item_ev;

  always #5 clk = ~clk;

  dual_digit_mux #(.CLK_HZ(CLK_HZ), .SWITCH_HZ(SWITCH_HZ)) u0 (
    .clk(clk), .rst(rst), .left_nib(left_nib), .right_nib(right_nib),
    .seg_n(seg_n), .dig_en_n(dig_en_n), .sum(sum));

  always @(posedge clk) n <= rst ? 0 : n + 1;

  function automatic logic [6:0] shape(input logic [3:0] v);
    logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                           7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    return ~t[v];
  endfunction

  task automatic step(input logic r, input logic [3:0] l, input logic [3:0] rt, input string tag);
    item_t it;
    bit right_on;
    @(negedge clk);
    rst = r; left_nib = l; right_nib = rt;
    #1;
    right_on = ((n / HOLD) % 2) == 1;
    it.tag = tag;
    it.en  = right_on ? 2'b10 : 2'b01;
    it.seg = shape(right_on ? rt : l);
    it.sm  = 5'(l) + 5'(rt);
    q.push_back(it);
    -> item_ev;
  endtask

  task automatic check(input string what, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at n=%0d", what, act, exp, n);
    end
  endtask

  initial forever begin
    item_t it;
    @(item_ev);
    #1;
    it = q.pop_front();
    check({it.tag, " R2 R3 dig_en_n"}, {5'b0, dig_en_n}, {5'b0, it.en});
    check({it.tag, " R4 R5 R7 seg_n"}, seg_n, it.seg);
    check({it.tag, " R6 sum"}, {2'b0, sum}, {2'b0, it.sm});
  end

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    // R1: reset state
    step(1, 4'h3, 4'hC, "R1");
    step(1, 4'h7, 4'h9, "R1");
    // main sweep: every pair, many digit flips (R3, R4, R5, R6, R7)
    for (int i = 0; i < 256; i++)
      step(0, 4'(i >> 4), 4'(i * 7 + 3), "main");
    // carry boundary for R6
    step(0, 4'hF, 4'hF, "carry");
    step(0, 4'h0, 4'h0, "zero");
    // mid-phase reset, count restarts (R1)
    for (int i = 0; i < 3; i++) step(0, 4'(i), 4'hE, "pre");
    step(1, 4'h5, 4'hA, "R1 mid");
    for (int i = 0; i < 3 * HOLD; i++)
      step(0, 4'(i), 4'(15 - i), "R1 restart");
    @(negedge clk); #3;
    finish_up();
  end
endmodule